// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the word address for a four-beat burst memory access. A new burst starts when either of two active-low address-status strobes is low at a rising clock edge. The external address is then captured. Its two low bits become the start offset of the burst, and the beat index restarts at zero. On each later cycle with no strobe, an active-low advance input either steps the beat index or holds it. Holding suspends the burst, so the current address is used again.

A mode input picks the beat order, and it is captured only when a burst loads. In interleaved order each offset is the start offset XOR the beat index. In linear order the offset counts upward modulo four from the start. The upper address bits are registered with the offset and pass through unchanged for the whole burst. The processor-side strobe is qualified by an active-low chip enable. The controller-side strobe is not qualified by it.

Every input and output is a plain control or address pin. Nothing flows through the block as a stream, so there is no valid/ready handshake and no back-pressure. The outputs are valid in every cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `burst_ofs` and `word_addr` to zero. It also sets the beat index to zero and the order to linear.
- R2: When `ctrl_strb_n` is low at a rising edge, the block loads `addr_in`, whatever the chip enable is. From the next cycle `word_addr` equals the loaded address, and the beat index restarts at zero.
- R3: When `proc_strb_n` is low and `chip_en_n` is low at a rising edge, the block loads `addr_in` in the same way as R2.
- R4: When `proc_strb_n` is low while `chip_en_n` is high, and `ctrl_strb_n` is high, the processor-side strobe is ignored. The cycle then acts as an advance or a hold, as `adv_n` selects.
- R5: Interleaved order (`order_sel` = 1 at load): `burst_ofs` = start offset XOR beat index, bit by bit. For a start of 01 the offsets are 01, 00, 11, 10.
- R6: Linear order (`order_sel` = 0 at load): `burst_ofs` = (start offset + beat index) mod 4. For a start of 10 the offsets are 10, 11, 00, 01.
- R7: With both strobes inactive and `adv_n` low, the beat index steps by one. After the fourth beat it wraps, so the offset returns to the start offset.
- R8: With both strobes inactive and `adv_n` high, `burst_ofs` and `word_addr` hold their values.
- R9: `word_addr[15:2]` equals bits 15:2 of the loaded address for the whole burst. `word_addr[1:0]` equals `burst_ofs`.
- R10: `order_sel` is sampled only when a burst loads. Changing it in the middle of a burst does not change the beat order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| proc_strb_n | input | 1 | Processor-side address strobe, active low, qualified by `chip_en_n` |
| ctrl_strb_n | input | 1 | Controller-side address strobe, active low, unqualified |
| chip_en_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Burst advance, active low; high means suspend |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_in | input | 16 | External word address |
| burst_ofs | output | 2 | Current burst offset |
| word_addr | output | 16 | Upper loaded bits joined with the burst offset |

## Verification
The assertions check four things on every cycle:
- A load makes the output equal the captured address.
- Each advance steps the beat index by exactly one.
- A suspended cycle, including one with a masked processor strobe, leaves the address unchanged.
- The upper bits and the captured order change only on a load.

The values of the two beat orders, the wrap back to the start offset, and the effect of a mid-burst mode change can only be shown by the bench's directed bursts and random sequences. The bench compares these against its own reference model.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } order_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CTRL = 2'd1,
    SRC_PROC = 2'd2
  } load_src_e;
endpackage

// File: rtl/burst_load_ctl.sv
module burst_load_ctl
  import burst_pkg::*;
(
  input  logic      proc_strb_n,
  input  logic      ctrl_strb_n,
  input  logic      chip_en_n,
  output logic      load,
  output load_src_e load_src
);
  always_comb begin
    load_src = SRC_NONE;
    if (!ctrl_strb_n)
      load_src = SRC_CTRL;
    else if (!proc_strb_n && !chip_en_n)
      load_src = SRC_PROC;
  end

  assign load = (load_src != SRC_NONE);
endmodule

// File: rtl/burst_beat_reg.sv
module burst_beat_reg
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic                     adv_n,
  input  logic                     order_sel,
  input  logic [ADDR_W-1:0]        addr_in,
  output logic [ADDR_W-BEAT_W-1:0] upper_q,
  output logic [BEAT_W-1:0]        start_q,
  output logic [BEAT_W-1:0]        beat_q,
  output order_e                   order_q
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q <= '0;
      start_q <= '0;
      beat_q  <= '0;
      order_q <= ORDER_LINEAR;
    end else if (load) begin
      upper_q <= addr_in[ADDR_W-1:BEAT_W];
      start_q <= addr_in[BEAT_W-1:0];
      beat_q  <= '0;
      order_q <= order_e'(order_sel);
    end else if (!adv_n) begin
      beat_q  <= beat_q + 1'b1;
    end
  end

  // R7
  beat_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv_n) |=> beat_q == BEAT_W'($past(beat_q) + 1'b1));

  // R10
  order_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(order_q));

  // R2
  beat_restart_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> beat_q == '0);

  // R9
  upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> upper_q == $past(upper_q[UPPER_W-1:0]));
endmodule

// File: rtl/burst_ofs_map.sv
module burst_ofs_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  input  order_e            order,
  output logic [BEAT_W-1:0] ofs
);
  logic [BEAT_W-1:0] ofs_lin;
  logic [BEAT_W-1:0] ofs_ilv;

  assign ofs_lin = start + beat;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ofs_ilv[b] = start[b] ^ beat[b];
  end

  assign ofs = (order == ORDER_INTERLEAVE) ? ofs_ilv : ofs_lin;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              proc_strb_n,
  input  logic              ctrl_strb_n,
  input  logic              chip_en_n,
  input  logic              adv_n,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [BEAT_W-1:0] burst_ofs,
  output logic [ADDR_W-1:0] word_addr
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic               load;
  load_src_e          load_src;
  logic [UPPER_W-1:0] upper_q;
  logic [BEAT_W-1:0]  start_q;
  logic [BEAT_W-1:0]  beat_q;
  order_e             order_q;

  burst_load_ctl u_ctl (
    .proc_strb_n (proc_strb_n),
    .ctrl_strb_n (ctrl_strb_n),
    .chip_en_n   (chip_en_n),
    .load        (load),
    .load_src    (load_src)
  );

  burst_beat_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .adv_n     (adv_n),
    .order_sel (order_sel),
    .addr_in   (addr_in),
    .upper_q   (upper_q),
    .start_q   (start_q),
    .beat_q    (beat_q),
    .order_q   (order_q)
  );

  burst_ofs_map #(.BEAT_W(BEAT_W)) u_map (
    .start (start_q),
    .beat  (beat_q),
    .order (order_q),
    .ofs   (burst_ofs)
  );

  assign word_addr = {upper_q, burst_ofs};

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> word_addr == $past(addr_in));

  // R3
  proc_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!proc_strb_n && !chip_en_n) |=> word_addr == $past(addr_in));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_strb_n && (proc_strb_n || chip_en_n) && adv_n) |=> $stable(word_addr));

  // R4
  masked_proc_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_strb_n && !proc_strb_n && chip_en_n) |-> (load_src == SRC_NONE));
endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  localparam int ADDR_W = 16;
  localparam int BEAT_W = 2;

  logic              clk = 1'b0;
  logic              rst;
  logic              proc_strb_n, ctrl_strb_n, chip_en_n, adv_n, order_sel;
  logic [ADDR_W-1:0] addr_in;
  logic [BEAT_W-1:0] burst_ofs;
  logic [ADDR_W-1:0] word_addr;

  int checks = 0;
  int fails  = 0;

  logic [ADDR_W-BEAT_W-1:0] m_up;
  logic [BEAT_W-1:0]        m_start, m_beat;
  logic                     m_mode;

  always #10 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) dut (
    .clk(clk), .rst(rst), .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n),
    .chip_en_n(chip_en_n), .adv_n(adv_n), .order_sel(order_sel),
    .addr_in(addr_in), .burst_ofs(burst_ofs), .word_addr(word_addr)
  );

  function automatic logic [BEAT_W-1:0] exp_ofs(logic [BEAT_W-1:0] s,
                                                logic [BEAT_W-1:0] b, logic m);
    return m ? (s ^ b) : BEAT_W'(s + b);
  endfunction

  task automatic check(string tag, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(logic r, logic pn, logic cn, logic ce, logic an,
                      logic ms, logic [ADDR_W-1:0] a);
    string tag, otag;
    rst = r; proc_strb_n = pn; ctrl_strb_n = cn; chip_en_n = ce;
    adv_n = an; order_sel = ms; addr_in = a;
    @(posedge clk);
    if (r) begin
      m_up = '0; m_start = '0; m_beat = '0; m_mode = 1'b0; tag = "R1";
    end else if (!cn || (!pn && !ce)) begin
      m_up = a[ADDR_W-1:BEAT_W]; m_start = a[BEAT_W-1:0];
      m_beat = '0; m_mode = ms;
      tag = !cn ? "R2" : "R3";
    end else begin
      if (!an) begin m_beat = m_beat + 1'b1; tag = "R7"; end
      else tag = "R8";
      if (!pn) tag = "R4";
    end
    @(negedge clk);
    otag = m_mode ? "R5" : "R6";
    check(tag, word_addr, {m_up, exp_ofs(m_start, m_beat, m_mode)});
    check(otag, ADDR_W'(burst_ofs), ADDR_W'(exp_ofs(m_start, m_beat, m_mode)));
    check("R9", ADDR_W'(word_addr[ADDR_W-1:BEAT_W]), ADDR_W'(m_up));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    logic [BEAT_W-1:0] seen;
    void'($urandom(32'd2024));
    rst = 1'b1; proc_strb_n = 1'b1; ctrl_strb_n = 1'b1; chip_en_n = 1'b1;
    adv_n = 1'b1; order_sel = 1'b0; addr_in = '0;
    @(negedge clk);
    // R1: reset state
    step(1, 1, 1, 1, 1, 0, 16'hFFFF);
    check("R1", word_addr, 16'h0000);
    // R2 + R5: interleaved burst from offset 01, wrap after four beats (R7)
    step(0, 1, 0, 1, 1, 1, 16'hABCD);
    check("R5", ADDR_W'(burst_ofs), 16'd1);
    for (int i = 0; i < 4; i++) step(0, 1, 1, 1, 0, 1, 16'h0);
    check("R7", ADDR_W'(burst_ofs), 16'd1);
    // R3 + R6: linear burst from offset 10 via processor strobe
    step(0, 0, 1, 0, 1, 0, 16'h1236);
    check("R6", ADDR_W'(burst_ofs), 16'd2);
    step(0, 1, 1, 1, 0, 0, 16'h0);
    check("R6", ADDR_W'(burst_ofs), 16'd3);
    step(0, 1, 1, 1, 0, 0, 16'h0);
    check("R6", ADDR_W'(burst_ofs), 16'd0);
    // R8: suspend holds the address
    step(0, 1, 1, 1, 1, 0, 16'h0);
    check("R8", word_addr, 16'h1234);
    // R4: processor strobe with chip disabled is ignored (suspend, then advance)
    step(0, 0, 1, 1, 1, 1, 16'h5555);
    check("R4", word_addr, 16'h1234);
    step(0, 0, 1, 1, 0, 1, 16'h5555);
    check("R4", word_addr, 16'h1235);
    // R10: mode flips mid-burst without effect
    step(0, 1, 0, 1, 1, 0, 16'h00F1);
    step(0, 1, 1, 1, 0, 1, 16'h0);
    seen = burst_ofs;
    check("R10", ADDR_W'(seen), 16'd2);
    step(0, 1, 1, 1, 0, 1, 16'h0);
    check("R10", ADDR_W'(burst_ofs), 16'd3);
    // Random sequences
    for (int i = 0; i < 600; i++) begin
      logic r;
      r = ($urandom % 50) == 0;
      step(r, ($urandom % 4) != 0, ($urandom % 5) != 0, $urandom % 2,
           ($urandom % 3) == 0, $urandom % 2, ADDR_W'($urandom));
    end
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule